// File: doc/BRIEF.md
# Circular Descriptor Ring Walker

This block is the fetch side of one DMA pipe. Software places 8-byte transfer descriptors in a ring in memory, programs the ring base and size, and then moves work to the engine by writing the new producer position as a byte offset. The engine reads one descriptor at a time from memory, starting at its consumer offset. It hands the byte count to a stub data mover, which stands in for the real payload mover and finishes after one cycle per byte. It then reports the finished descriptor as an event. After the event is accepted the consumer offset steps forward by 8, and it returns to zero when it reaches the ring size. The engine stops when the consumer offset equals the producer offset.

Each descriptor word, as returned on the 64-bit read response, has the buffer address in bits 31:0, the byte count in bits 47:32 and the flag field in bits 63:48. Within the flag field, bit 15 asks for an interrupt, bit 14 marks end of transfer and bit 13 marks end of block. The engine passes the flag field through unchanged. A halt bit freezes the walk and keeps its position. The enable bit gates new fetches. A per-pipe clear, written 1 and then 0, puts every pipe register and the consumer offset back to zero.

The memory read port and the event port are valid/ready streams. A raised `mem_req_valid` stays high, with a stable address, until `mem_req_ready` is seen. A raised `evt_valid` stays high, with stable payload, until `evt_ready` is seen. A read response is taken only while `mem_rsp_ready` is high. The register port is plain: a write strobe with index and data, and a combinational read by index.

Register indices (both ports): 0 control, 1 halt, 2 pipe clear, 3 ring base, 4 ring size in bytes, 5 producer offset, 6 consumer offset (read only). Control bit 1 enables the pipe, bit 3 selects device-to-memory direction and bit 5 selects system mode. All other control bits read 0.

Top module: `desc_ring_walker`

## Requirements
- R1: After `rst_n` is low, every register reads 0, `cons_offset` is 0 and neither `mem_req_valid` nor `evt_valid` is high.
- R2: When the pipe is enabled and not halted, and the consumer offset differs from the producer offset, the engine raises `mem_req_valid` with address `base + consumer offset` one cycle after it sees the condition. It holds the request until `mem_req_ready` is seen, then raises `mem_rsp_ready` until a response arrives.
- R3: For a response with a nonzero byte count N (bits 47:32), `evt_valid` rises N+1 cycles after the response cycle. It carries flags = bits 63:48, buffer address = bits 31:0 and `evt_offset` = the descriptor's byte offset, and it holds until `evt_ready` is seen.
- R4: For a response with byte count 0, `evt_valid` rises in the cycle after the response cycle, and the flags are still reported.
- R5: On each event handshake the consumer offset grows by 8, or becomes 0 when offset+8 is at least the ring size. The walk ends when the consumer offset equals the producer offset.
- R6: The low 3 bits of a producer offset write are dropped (writing 0x13 reads back 0x10).
- R7: While the halt register bit 0 is 1, no new fetch is issued and the consumer offset holds. Writing 0 resumes from the same offset.
- R8: Clearing the enable bit blocks new fetches. A request already raised completes through its event.
- R9: Writing 1 and then 0 to the pipe clear register returns control, halt, base, size, producer and consumer offsets to 0. While the bit is 1, writes to other registers are ignored.
- R10: The low 3 bits of the ring base are dropped, so fetch addresses are 8-byte aligned.
- R11: Control reads back only bits 1, 3 and 5 (writing all ones reads 0x2A).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_waddr | input | 3 | Register write index |
| reg_wdata | input | ADDR_W | Register write data |
| reg_raddr | input | 3 | Register read index |
| reg_rdata | output | ADDR_W | Register read data (combinational) |
| mem_req_valid | output | 1 | Descriptor read request valid |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | ADDR_W | Descriptor byte address |
| mem_rsp_valid | input | 1 | Read response valid |
| mem_rsp_ready | output | 1 | Engine takes the response |
| mem_rsp_data | input | 64 | Descriptor word |
| evt_valid | output | 1 | Processed-descriptor event valid |
| evt_ready | input | 1 | Event consumer ready |
| evt_flags | output | 16 | Descriptor flag field |
| evt_buf_addr | output | 32 | Descriptor buffer address |
| evt_offset | output | OFS_W | Byte offset of the reported descriptor |
| cons_offset | output | OFS_W | Current consumer byte offset |

## Verification
Two cases can fall in the same cycle. In the first, a write to the producer, halt or enable register lands while a descriptor is still in flight or its event is back-pressured. In the second, the consumer offset wraps in the same cycle that the event handshake completes. The bench drives pseudo-random ready patterns on both streams while it writes registers at arbitrary points of the walk. This includes dropping the enable bit in the cycle a request is pending, and running a walk that crosses the ring end. A behavioural reference model, stepped every clock, judges request, response-ready, event and offset outputs on each cycle.

// File: rtl/ring_walk_pkg.sv
package ring_walk_pkg;
  localparam int DESC_W     = 64;
  localparam int DESC_BYTES = 8;
  localparam int LEN_W      = 16;
  localparam int FLAG_W     = 16;
  localparam int BUF_W      = 32;
  localparam int REG_AW     = 3;

  localparam logic [REG_AW-1:0] RIX_CTRL  = 3'd0;
  localparam logic [REG_AW-1:0] RIX_HALT  = 3'd1;
  localparam logic [REG_AW-1:0] RIX_CLR   = 3'd2;
  localparam logic [REG_AW-1:0] RIX_BASE  = 3'd3;
  localparam logic [REG_AW-1:0] RIX_SIZE  = 3'd4;
  localparam logic [REG_AW-1:0] RIX_PROD  = 3'd5;
  localparam logic [REG_AW-1:0] RIX_CONS  = 3'd6;

  typedef struct packed {
    logic [FLAG_W-1:0] flags;
    logic [LEN_W-1:0]  count;
    logic [BUF_W-1:0]  buf_addr;
  } desc_t;

  typedef enum logic [2:0] {
    ST_IDLE, ST_REQ, ST_RSP, ST_MOVE, ST_EVT
  } walk_state_e;
endpackage

// File: rtl/ring_regs.sv
module ring_regs import ring_walk_pkg::*; #(
  parameter int ADDR_W = 32,
  parameter int OFS_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [REG_AW-1:0] waddr,
  input  logic [ADDR_W-1:0] wdata,
  input  logic [REG_AW-1:0] raddr,
  output logic [ADDR_W-1:0] rdata,
  input  logic [OFS_W-1:0]  cons,
  output logic              en,
  output logic              halt,
  output logic              pipe_clr,
  output logic [ADDR_W-1:0] base,
  output logic [OFS_W-1:0]  size,
  output logic [OFS_W-1:0]  prod
);
  localparam int AL = $clog2(DESC_BYTES);

  logic                 en_q, dir_q, sys_q, halt_q, clr_q;
  logic [ADDR_W-1:AL]   base_q;
  logic [OFS_W-1:AL]    size_q;
  logic [OFS_W-1:AL]    prod_q;
  logic                 unused_wdata_bit;

  assign unused_wdata_bit = wdata[2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clr_q <= 1'b0;
    end else if (we && waddr == RIX_CLR) begin
      clr_q <= wdata[0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= 1'b0; dir_q <= 1'b0; sys_q <= 1'b0; halt_q <= 1'b0;
      base_q <= '0; size_q <= '0; prod_q <= '0;
    end else if (clr_q) begin
      en_q <= 1'b0; dir_q <= 1'b0; sys_q <= 1'b0; halt_q <= 1'b0;
      base_q <= '0; size_q <= '0; prod_q <= '0;
    end else if (we) begin
      case (waddr)
        RIX_CTRL: begin
          en_q  <= wdata[1];
          dir_q <= wdata[3];
          sys_q <= wdata[5];
        end
        RIX_HALT: halt_q <= wdata[0];
        RIX_BASE: base_q <= wdata[ADDR_W-1:AL];
        RIX_SIZE: size_q <= wdata[OFS_W-1:AL];
        RIX_PROD: prod_q <= wdata[OFS_W-1:AL];
        default: ;
      endcase
    end
  end

  assign en       = en_q;
  assign halt     = halt_q;
  assign pipe_clr = clr_q;
  assign base     = {base_q, {AL{1'b0}}};
  assign size     = {size_q, {AL{1'b0}}};
  assign prod     = {prod_q, {AL{1'b0}}};

  always_comb begin
    rdata = '0;
    case (raddr)
      RIX_CTRL: rdata = ADDR_W'({sys_q, 1'b0, dir_q, 1'b0, en_q, 1'b0});
      RIX_HALT: rdata = ADDR_W'(halt_q);
      RIX_CLR:  rdata = ADDR_W'(clr_q);
      RIX_BASE: rdata = base;
      RIX_SIZE: rdata = ADDR_W'(size);
      RIX_PROD: rdata = ADDR_W'(prod);
      RIX_CONS: rdata = ADDR_W'(cons);
      default:  rdata = '0;
    endcase
  end
endmodule

// File: rtl/data_mover_stub.sv
module data_mover_stub import ring_walk_pkg::*; #(
  parameter int CNT_W = LEN_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             start,
  input  logic [CNT_W-1:0] len,
  output logic             done
);
  logic [CNT_W-1:0] cnt_q;
  logic             busy;

  assign busy = (cnt_q != '0);
  assign done = (cnt_q == CNT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (clr)    cnt_q <= '0;
    else if (start)  cnt_q <= len;
    else if (busy)   cnt_q <= cnt_q - CNT_W'(1);
  end

  // a new descriptor is never handed over while one is still moving
  assert_start_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !busy);
endmodule

// File: rtl/ring_walker.sv
module ring_walker import ring_walk_pkg::*; #(
  parameter int ADDR_W = 32,
  parameter int OFS_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pipe_clr,
  input  logic              en,
  input  logic              halt,
  input  logic [ADDR_W-1:0] base,
  input  logic [OFS_W-1:0]  size,
  input  logic [OFS_W-1:0]  prod,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [ADDR_W-1:0] mem_req_addr,
  input  logic              mem_rsp_valid,
  output logic              mem_rsp_ready,
  input  logic [DESC_W-1:0] mem_rsp_data,
  output logic              evt_valid,
  input  logic              evt_ready,
  output logic [FLAG_W-1:0] evt_flags,
  output logic [BUF_W-1:0]  evt_buf_addr,
  output logic              mv_start,
  output logic [LEN_W-1:0]  mv_len,
  input  logic              mv_done,
  output logic [OFS_W-1:0]  cons
);
  walk_state_e       st, st_n;
  logic [OFS_W-1:0]  cons_q, cons_n;
  logic [ADDR_W-1:0] addr_q;
  logic [FLAG_W-1:0] flags_q;
  logic [BUF_W-1:0]  bufa_q;
  logic [OFS_W:0]    step_sum;
  logic              wrap;
  desc_t             d;

  assign d        = mem_rsp_data;
  assign step_sum = {1'b0, cons_q} + (OFS_W+1)'(DESC_BYTES);
  assign wrap     = step_sum >= {1'b0, size};

  always_comb begin
    st_n   = st;
    cons_n = cons_q;
    case (st)
      ST_IDLE: if (en && !halt && cons_q != prod) st_n = ST_REQ;
      ST_REQ:  if (mem_req_ready) st_n = ST_RSP;
      ST_RSP:  if (mem_rsp_valid) st_n = (d.count == '0) ? ST_EVT : ST_MOVE;
      ST_MOVE: if (mv_done) st_n = ST_EVT;
      ST_EVT:  if (evt_ready) begin
        st_n   = ST_IDLE;
        cons_n = wrap ? '0 : step_sum[OFS_W-1:0];
      end
      default: st_n = ST_IDLE;
    endcase
    if (pipe_clr) begin
      st_n   = ST_IDLE;
      cons_n = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      cons_q  <= '0;
      addr_q  <= '0;
      flags_q <= '0;
      bufa_q  <= '0;
    end else begin
      st     <= st_n;
      cons_q <= cons_n;
      if (st == ST_IDLE) addr_q <= base + ADDR_W'(cons_q);
      if (st == ST_RSP && mem_rsp_valid) begin
        flags_q <= d.flags;
        bufa_q  <= d.buf_addr;
      end
    end
  end

  assign mem_req_valid = (st == ST_REQ);
  assign mem_req_addr  = addr_q;
  assign mem_rsp_ready = (st == ST_RSP);
  assign mv_start      = (st == ST_RSP) && mem_rsp_valid && (d.count != '0);
  assign mv_len        = d.count;
  assign evt_valid     = (st == ST_EVT);
  assign evt_flags     = flags_q;
  assign evt_buf_addr  = bufa_q;
  assign cons          = cons_q;

  assert_req_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready && !pipe_clr) |=>
      (mem_req_valid && $stable(mem_req_addr)));

  assert_evt_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_valid && !evt_ready && !pipe_clr) |=>
      (evt_valid && $stable(evt_flags) && $stable(evt_buf_addr) && $stable(cons)));

  assert_cons_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cons != $past(cons)) |->
      (cons == '0 || cons == $past(cons) + OFS_W'(DESC_BYTES)));

  assert_fetch_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_req_valid) |-> $past(en && !halt && !pipe_clr));
endmodule

// File: rtl/desc_ring_walker.sv
module desc_ring_walker import ring_walk_pkg::*; #(
  parameter int ADDR_W = 32,
  parameter int OFS_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [REG_AW-1:0] reg_waddr,
  input  logic [ADDR_W-1:0] reg_wdata,
  input  logic [REG_AW-1:0] reg_raddr,
  output logic [ADDR_W-1:0] reg_rdata,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [ADDR_W-1:0] mem_req_addr,
  input  logic              mem_rsp_valid,
  output logic              mem_rsp_ready,
  input  logic [DESC_W-1:0] mem_rsp_data,
  output logic              evt_valid,
  input  logic              evt_ready,
  output logic [FLAG_W-1:0] evt_flags,
  output logic [BUF_W-1:0]  evt_buf_addr,
  output logic [OFS_W-1:0]  evt_offset,
  output logic [OFS_W-1:0]  cons_offset
);
  logic              en, halt, pipe_clr;
  logic [ADDR_W-1:0] base;
  logic [OFS_W-1:0]  size, prod, cons;
  logic              mv_start, mv_done;
  logic [LEN_W-1:0]  mv_len;

  ring_regs #(.ADDR_W(ADDR_W), .OFS_W(OFS_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(reg_we), .waddr(reg_waddr),
    .wdata(reg_wdata), .raddr(reg_raddr), .rdata(reg_rdata), .cons(cons),
    .en(en), .halt(halt), .pipe_clr(pipe_clr), .base(base), .size(size),
    .prod(prod)
  );

  ring_walker #(.ADDR_W(ADDR_W), .OFS_W(OFS_W)) u_walk (
    .clk(clk), .rst_n(rst_n), .pipe_clr(pipe_clr), .en(en), .halt(halt),
    .base(base), .size(size), .prod(prod),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_ready(mem_rsp_ready), .mem_rsp_data(mem_rsp_data),
    .evt_valid(evt_valid), .evt_ready(evt_ready), .evt_flags(evt_flags),
    .evt_buf_addr(evt_buf_addr), .mv_start(mv_start), .mv_len(mv_len),
    .mv_done(mv_done), .cons(cons)
  );

  data_mover_stub #(.CNT_W(LEN_W)) u_mover (
    .clk(clk), .rst_n(rst_n), .clr(pipe_clr), .start(mv_start),
    .len(mv_len), .done(mv_done)
  );

  assign evt_offset  = cons;
  assign cons_offset = cons;
endmodule

// File: tb/test_desc_ring_walker.sv
module test_desc_ring_walker;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_waddr = '0;
  logic [31:0] reg_wdata = '0;
  logic [2:0]  reg_raddr = '0;
  logic [31:0] reg_rdata;
  logic        mem_req_valid, mem_rsp_ready, evt_valid;
  logic        mem_req_ready = 1'b0;
  logic [31:0] mem_req_addr;
  logic        mem_rsp_valid = 1'b0;
  logic [63:0] mem_rsp_data = '0;
  logic        evt_ready = 1'b0;
  logic [15:0] evt_flags, evt_offset, cons_offset;
  logic [31:0] evt_buf_addr;

  int checks = 0;
  int failures = 0;
  int cyc = 0;

  always #5 clk = ~clk;

  desc_ring_walker i_desc_ring_walker (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_waddr(reg_waddr),
    .reg_wdata(reg_wdata), .reg_raddr(reg_raddr), .reg_rdata(reg_rdata),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_ready(mem_rsp_ready), .mem_rsp_data(mem_rsp_data),
    .evt_valid(evt_valid), .evt_ready(evt_ready), .evt_flags(evt_flags),
    .evt_buf_addr(evt_buf_addr), .evt_offset(evt_offset),
    .cons_offset(cons_offset)
  );

  localparam logic [31:0] RING = 32'h1000_0000;

  function automatic logic [63:0] desc_word(input int idx);
    logic [15:0] cnt, flg;
    case (idx)
      0: begin cnt = 16'd0; flg = 16'h8000; end
      1: begin cnt = 16'd3; flg = 16'h4000; end
      2: begin cnt = 16'd1; flg = 16'h2000; end
      3: begin cnt = 16'd0; flg = 16'hE000; end
      4: begin cnt = 16'd5; flg = 16'h0000; end
      5: begin cnt = 16'd2; flg = 16'hA000; end
      default: begin cnt = 16'd0; flg = 16'h0000; end
    endcase
    return {flg, cnt, 32'h2000_0000 + 32'(idx) * 32'h100};
  endfunction

  task automatic check(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  // memory and ready patterns
  logic [15:0] lfsr = 16'hACE1;
  logic        pend = 1'b0;
  logic [63:0] pend_data = '0;

  always @(posedge clk) begin
    if (!rst_n) pend <= 1'b0;
    else begin
      if (mem_rsp_valid && mem_rsp_ready) pend <= 1'b0;
      if (mem_req_valid && mem_req_ready) begin
        pend      <= 1'b1;
        pend_data <= desc_word(int'((mem_req_addr - RING) >> 3));
      end
    end
  end

  always @(negedge clk) begin
    lfsr          <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    mem_req_ready <= lfsr[0] | lfsr[3];
    evt_ready     <= lfsr[1] | lfsr[6];
    mem_rsp_valid <= pend;
    mem_rsp_data  <= pend_data;
  end

  // behavioural reference model
  int          ph = 0;       // 0 idle,1 request,2 wait response,3 moving,4 event
  int          m_cnt = 0;
  bit          m_zero = 0;
  bit          m_en = 0, m_dir = 0, m_sys = 0, m_halt = 0, m_clr = 0;
  logic [31:0] m_base = '0;
  logic [15:0] m_size = '0, m_prod = '0, m_cons = '0;
  logic [15:0] m_flags = '0;
  logic [31:0] m_buf = '0;

  always @(posedge clk) begin
    if (!rst_n) begin
      ph = 0; m_cnt = 0; m_zero = 0; m_en = 0; m_dir = 0; m_sys = 0;
      m_halt = 0; m_clr = 0; m_base = '0; m_size = '0; m_prod = '0;
      m_cons = '0; m_flags = '0; m_buf = '0;
    end else begin
      automatic bit old_clr = m_clr;
      automatic bit go = m_en && !m_halt && (m_cons != m_prod);
      if (reg_we && reg_waddr == 3'd2) m_clr = reg_wdata[0];
      if (old_clr) begin
        m_en = 0; m_dir = 0; m_sys = 0; m_halt = 0;
        m_base = '0; m_size = '0; m_prod = '0;
      end else if (reg_we) begin
        case (reg_waddr)
          3'd0: begin m_en = reg_wdata[1]; m_dir = reg_wdata[3]; m_sys = reg_wdata[5]; end
          3'd1: m_halt = reg_wdata[0];
          3'd3: m_base = reg_wdata & ~32'd7;
          3'd4: m_size = reg_wdata[15:0] & ~16'd7;
          3'd5: m_prod = reg_wdata[15:0] & ~16'd7;
          default: ;
        endcase
      end
      if (old_clr) begin
        ph = 0; m_cons = '0; m_cnt = 0;
      end else begin
        case (ph)
          0: if (go) ph = 1;
          1: if (mem_req_ready) ph = 2;
          2: if (mem_rsp_valid) begin
            m_flags = mem_rsp_data[63:48];
            m_buf   = mem_rsp_data[31:0];
            m_cnt   = int'(mem_rsp_data[47:32]);
            m_zero  = (m_cnt == 0);
            ph      = m_zero ? 4 : 3;
          end
          3: begin
            if (m_cnt == 1) ph = 4;
            m_cnt--;
          end
          4: if (evt_ready) begin
            ph = 0;
            if (int'(m_cons) + 8 >= int'(m_size)) m_cons = '0;
            else m_cons = m_cons + 16'd8;
          end
          default: ph = 0;
        endcase
      end
    end
  end

  logic [31:0] exp_addr = '0;
  always @(posedge clk) begin
    if (ph == 0) exp_addr <= m_base + {16'h0, m_cons};
  end

  // per-cycle comparison against the model
  always @(posedge clk) begin
    #2;
    if (rst_n) begin
      automatic string rtag = m_halt ? "R7" : (!m_en ? "R8" : "R2");
      check(mem_req_valid == (ph == 1), rtag, 64'(mem_req_valid), 64'(ph == 1));
      check(mem_rsp_ready == (ph == 2), "R2", 64'(mem_rsp_ready), 64'(ph == 2));
      if (ph == 1)
        check(mem_req_addr == exp_addr, "R2 R10", 64'(mem_req_addr), 64'(exp_addr));
      check(evt_valid == (ph == 4), m_zero ? "R4" : "R3", 64'(evt_valid), 64'(ph == 4));
      if (ph == 4)
        check(evt_flags == m_flags && evt_buf_addr == m_buf && evt_offset == m_cons,
              "R3", {evt_flags, evt_offset, evt_buf_addr}, {m_flags, m_cons, m_buf});
      check(cons_offset == m_cons, m_clr ? "R9" : "R5", 64'(cons_offset), 64'(m_cons));
    end
  end

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_waddr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd_check(input logic [2:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    reg_raddr = a;
    #1;
    check(reg_rdata == exp, tag, 64'(reg_rdata), 64'(exp));
  endtask

  task automatic wait_cons(input logic [15:0] v, input string tag);
    int n = 0;
    while (cons_offset != v && n < 400) begin
      @(negedge clk);
      n++;
    end
    check(cons_offset == v, tag, 64'(cons_offset), 64'(v));
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      failures++;
      $display("FAIL watchdog R5 actual=%0d expected=%0d", cyc, 150000);
      finish_run();
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    for (int i = 0; i < 7; i++) rd_check(3'(i), 32'h0, "R1");
    check(!mem_req_valid && !evt_valid, "R1", 64'({mem_req_valid, evt_valid}), 64'h0);

    // R10 base alignment, size, R11 control bits
    wr(3'd3, RING | 32'd3);
    rd_check(3'd3, RING, "R10");
    wr(3'd4, 32'd48);
    wr(3'd0, 32'hFFFF_FFFF);
    rd_check(3'd0, 32'h2A, "R11");

    // R6 producer low bits dropped, first walk
    wr(3'd5, 32'h13);
    rd_check(3'd5, 32'h10, "R6");
    wait_cons(16'h10, "R5");

    // walk across the ring end
    wr(3'd5, 32'h08);
    wait_cons(16'h08, "R5");

    // R7 halt holds position, resume continues
    wr(3'd1, 32'h1);
    wr(3'd5, 32'h28);
    repeat (40) @(negedge clk);
    rd_check(3'd6, 32'h08, "R7");
    wr(3'd1, 32'h0);
    wait_cons(16'h28, "R7");

    // R8 disable while a request is pending
    wr(3'd5, 32'h20);
    while (!mem_req_valid) @(negedge clk);
    wr(3'd0, 32'h0);
    repeat (60) @(negedge clk);
    rd_check(3'd6, 32'h00, "R8");
    wr(3'd0, 32'h2);
    wait_cons(16'h20, "R8");

    // R9 pipe clear pulse, with a write ignored while clear is held
    wr(3'd2, 32'h1);
    wr(3'd5, 32'h18);
    rd_check(3'd5, 32'h0, "R9");
    wr(3'd2, 32'h0);
    rd_check(3'd0, 32'h0, "R9");
    rd_check(3'd1, 32'h0, "R9");
    rd_check(3'd3, 32'h0, "R9");
    rd_check(3'd4, 32'h0, "R9");
    rd_check(3'd5, 32'h0, "R9");
    rd_check(3'd6, 32'h0, "R9");
    rd_check(3'd2, 32'h0, "R9");
    repeat (5) @(negedge clk);
    finish_run();
  end
endmodule